// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler with Postponed Refresh Credits

This block decides when a DDR SDRAM controller must spend command slots on refresh. An interval timer on the command clock produces one refresh credit per average refresh period. The credits build up while the command arbiter is busy, up to a limit of eight owed refreshes. The block asks the arbiter for an auto-refresh when the arbiter is idle. The request becomes insistent once half the credit limit is reached. At the limit it raises an urgent flag, and while that flag is up the arbiter must stop opening rows.

Each refresh that is granted pays back one credit. It also starts a guard window that covers the refresh cycle time, and no activate and no further refresh may be issued inside it. Self-refresh is a separate path. An enter request drops clock enable and holds it low until an exit request arrives. While the device is in self-refresh the interval timer is parked and the credits are cleared. After exit, two separate delays run: one for non-read commands, and a much longer one for reads. Normal refresh counting starts again once the longer delay has run out.

Top module: `refresh_sched`

## Requirements
- R1: After reset: ref_req=0, ref_urgent=0, act_block=0, busy=0, cke=1, nonread_ok=1, read_ok=1.
- R2: In normal operation the interval timer adds one credit every INTERVAL_CYC cycles. It keeps running while a refresh is in progress.
- R3: ref_req is 1 exactly when all of these hold: the block is in normal operation, no refresh guard window is open, and the credit count is nonzero. In addition, either arb_idle=1 or the credit count is at least LOW_THRESH (4).
- R4: Credits saturate at MAX_CREDIT (8), and a further interval then adds nothing. ref_urgent=1 exactly when the block is in normal operation and credits equal MAX_CREDIT.
- R5: ref_grant in a cycle with ref_req=1 removes one credit. If an interval ends in the same cycle, the count stays unchanged. ref_grant while ref_req=0 has no effect.
- R6: An accepted grant opens a guard window of RFC_CYC-1 cycles, starting on the next cycle. During the window busy=1, act_block=1 and ref_req=0.
- R7: sr_enter_req is accepted in normal operation when no guard window is open and no grant is accepted in that cycle. cke is 0 from the next cycle on and stays 0 until sr_exit_req arrives. During self-refresh and its exit delay, credits are cleared and the timer is held at zero.
- R8: After an accepted sr_exit_req, cke=1 from the next cycle on. nonread_ok is 0 for the first XS_NONREAD_CYC cycles and then 1.
- R9: read_ok stays 0 for XS_READ_CYC cycles after the exit request is accepted. The block then returns to normal operation, and the timer starts again from zero.
- R10: act_block equals busy OR ref_urgent. busy is 1 whenever the block is not in normal operation or a guard window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_idle | input | 1 | Arbiter has no pending work |
| ref_grant | input | 1 | Arbiter issues the requested auto-refresh this cycle |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Auto-refresh wanted |
| ref_urgent | output | 1 | Credit limit reached, refresh must go first |
| act_block | output | 1 | Arbiter must not issue activates |
| busy | output | 1 | Refresh guard window or self-refresh in progress |
| cke | output | 1 | Clock enable to the device |
| nonread_ok | output | 1 | Non-read commands allowed |
| read_ok | output | 1 | Read commands allowed |

## Verification
The request and urgency outputs are combinational on the registered credit count and arb_idle. A grant or interval end therefore shows up on them one cycle after the edge that samples it. The guard window, the clock-enable change and both exit delays all count from that same edge: RFC_CYC-1, XS_NONREAD_CYC and XS_READ_CYC cycles respectively. The bench drives inputs at the falling edge and compares every output against a cycle model before driving new inputs. The comparison is therefore made after a full half-period of settling, and each due cycle is the one the model's register step predicts.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        SR_NORMAL = 2'd0,
        SR_HOLD   = 2'd1,
        SR_WAKE   = 2'd2
    } sr_state_e;

    // Saturating credit update: one in per interval end, one out per refresh.
    function automatic int credit_step(int cur, bit inc, bit dec, int cap);
        if (inc && !dec)
            return (cur >= cap) ? cap : cur + 1;
        else if (dec && !inc)
            return (cur == 0) ? 0 : cur - 1;
        return cur;
    endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
    parameter int INTERVAL_CYC = 1300
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst || !run)
            tmr <= '0;
        else if (tmr == LAST)
            tmr <= '0;
        else
            tmr <= tmr + 1'b1;
    end

    assign tick = run && (tmr == LAST);
endmodule

// File: rtl/refsch_credit.sv
module refsch_credit
    import refsch_pkg::*;
#(
    parameter int MAX_CREDIT = 8,
    parameter int LOW_THRESH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic grant,
    input  logic arb_idle,
    input  logic guard_open,
    output logic [$clog2(MAX_CREDIT+1)-1:0] credit,
    output logic ref_req,
    output logic ref_urgent,
    output logic grant_acc
);
    localparam int CW = $clog2(MAX_CREDIT + 1);
    localparam logic [CW-1:0] CAP = CW'(MAX_CREDIT);
    localparam logic [CW-1:0] THR = CW'(LOW_THRESH);

    assign ref_req    = run && !guard_open && (credit != '0) &&
                        (arb_idle || credit >= THR);
    assign ref_urgent = run && (credit == CAP);
    assign grant_acc  = grant && ref_req;

    always_ff @(posedge clk) begin
        if (rst || !run)
            credit <= '0;
        else
            credit <= CW'(credit_step(int'(credit), tick, grant_acc, MAX_CREDIT));
    end
endmodule

// File: rtl/refsch_guard.sv
module refsch_guard #(
    parameter int RFC_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic open_win
);
    localparam int RW = $clog2(RFC_CYC);
    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= RW'(RFC_CYC - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign open_win = (cnt != '0);
endmodule

// File: rtl/refsch_srfsm.sv
module refsch_srfsm
    import refsch_pkg::*;
#(
    parameter int XS_NONREAD_CYC = 13,
    parameter int XS_READ_CYC    = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enter_ok,
    input  logic      enter_req,
    input  logic      exit_req,
    output sr_state_e state,
    output logic      cke,
    output logic      nonread_ok,
    output logic      read_ok
);
    localparam int XW = $clog2(XS_READ_CYC);
    localparam logic [XW-1:0] XNR  = XW'(XS_NONREAD_CYC);
    localparam logic [XW-1:0] XEND = XW'(XS_READ_CYC - 1);

    logic [XW-1:0] xcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SR_NORMAL;
            xcnt  <= '0;
        end else begin
            case (state)
                SR_NORMAL: if (enter_req && enter_ok) state <= SR_HOLD;
                SR_HOLD: if (exit_req) begin
                    state <= SR_WAKE;
                    xcnt  <= '0;
                end
                SR_WAKE: begin
                    if (xcnt == XEND) state <= SR_NORMAL;
                    else xcnt <= xcnt + 1'b1;
                end
                default: state <= SR_NORMAL;
            endcase
        end
    end

    assign cke        = (state != SR_HOLD);
    assign read_ok    = (state == SR_NORMAL);
    assign nonread_ok = read_ok || (state == SR_WAKE && xcnt >= XNR);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int INTERVAL_CYC   = 1300,
    parameter int RFC_CYC        = 12,
    parameter int MAX_CREDIT     = 8,
    parameter int LOW_THRESH     = 4,
    parameter int XS_NONREAD_CYC = 13,
    parameter int XS_READ_CYC    = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_idle,
    input  logic ref_grant,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic act_block,
    output logic busy,
    output logic cke,
    output logic nonread_ok,
    output logic read_ok
);
    localparam int CW = $clog2(MAX_CREDIT + 1);

    sr_state_e     state;
    logic          run, tick, guard_open, grant_acc;
    logic [CW-1:0] credit;

    assign run = (state == SR_NORMAL);

    refsch_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_ivl (
        .clk(clk), .rst(rst), .run(run), .tick(tick)
    );

    refsch_credit #(.MAX_CREDIT(MAX_CREDIT), .LOW_THRESH(LOW_THRESH)) u_cred (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .grant(ref_grant),
        .arb_idle(arb_idle), .guard_open(guard_open), .credit(credit),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .grant_acc(grant_acc)
    );

    refsch_guard #(.RFC_CYC(RFC_CYC)) u_grd (
        .clk(clk), .rst(rst), .start(grant_acc), .open_win(guard_open)
    );

    refsch_srfsm #(.XS_NONREAD_CYC(XS_NONREAD_CYC), .XS_READ_CYC(XS_READ_CYC)) u_sr (
        .clk(clk), .rst(rst), .enter_ok(!guard_open && !grant_acc),
        .enter_req(sr_enter_req), .exit_req(sr_exit_req), .state(state),
        .cke(cke), .nonread_ok(nonread_ok), .read_ok(read_ok)
    );

    assign busy      = !run || guard_open;
    assign act_block = busy || ref_urgent;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
    parameter int MAX_CREDIT = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] credit,
    input logic          tick,
    input logic          grant_acc,
    input logic          ref_req,
    input logic          ref_urgent,
    input logic          act_block,
    input logic          busy,
    input logic          cke,
    input logic          sr_exit_req,
    input logic          nonread_ok,
    input logic          read_ok
);
    // R4
    credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        credit <= CW'(MAX_CREDIT));
    // R5
    credit_pay_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_acc && !tick && !busy) |=> (credit == $past(credit) - 1'b1));
    // R6
    guard_open_chk: assert property (@(posedge clk) disable iff (rst)
        grant_acc |=> (busy && !ref_req));
    // R3
    req_needs_credit_chk: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> (credit != '0 && cke));
    // R10
    urgent_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> act_block);
    // R7
    hold_cke_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && !sr_exit_req) |=> !cke);
    // R9
    read_after_nonread_chk: assert property (@(posedge clk) disable iff (rst)
        read_ok |-> nonread_ok);
endmodule

bind refresh_sched refsch_chk #(.MAX_CREDIT(MAX_CREDIT), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .credit(credit), .tick(tick), .grant_acc(grant_acc),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .act_block(act_block),
    .busy(busy), .cke(cke), .sr_exit_req(sr_exit_req),
    .nonread_ok(nonread_ok), .read_ok(read_ok)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int IV = 24, RFC = 5, MAXC = 8, LOW = 4, XNR = 4, XRD = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic arb_idle = 1'b0, ref_grant = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
    logic ref_req, ref_urgent, act_block, busy, cke, nonread_ok, read_ok;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    refresh_sched #(.INTERVAL_CYC(IV), .RFC_CYC(RFC), .MAX_CREDIT(MAXC),
        .LOW_THRESH(LOW), .XS_NONREAD_CYC(XNR), .XS_READ_CYC(XRD)) u0 (
        .clk(clk), .rst(rst), .arb_idle(arb_idle), .ref_grant(ref_grant),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .act_block(act_block),
        .busy(busy), .cke(cke), .nonread_ok(nonread_ok), .read_ok(read_ok));

    // Cycle model built from the requirements (0 normal, 1 self-refresh, 2 waking)
    int m_st, m_tmr, m_cr, m_grd, m_xs;
    int urgent_seen = 0;

    function automatic bit e_req();
        return m_st == 0 && m_grd == 0 && m_cr > 0 && (arb_idle || m_cr >= LOW);
    endfunction
    function automatic bit e_urg();   return m_st == 0 && m_cr == MAXC; endfunction
    function automatic bit e_busy();  return m_st != 0 || m_grd != 0; endfunction
    function automatic bit e_cke();   return m_st != 1; endfunction
    function automatic bit e_rd();    return m_st == 0; endfunction
    function automatic bit e_nrd();   return m_st == 0 || (m_st == 2 && m_xs >= XNR); endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_tmr <= 0; m_cr <= 0; m_grd <= 0; m_xs <= 0;
        end else begin
            automatic bit tk  = (m_st == 0) && (m_tmr == IV - 1);
            automatic bit acc = ref_grant && e_req();
            m_tmr <= (m_st != 0 || tk) ? 0 : m_tmr + 1;
            if (m_st != 0) m_cr <= 0;
            else if (tk && !acc) m_cr <= (m_cr >= MAXC) ? MAXC : m_cr + 1;
            else if (acc && !tk) m_cr <= m_cr - 1;
            m_grd <= acc ? RFC - 1 : (m_grd != 0 ? m_grd - 1 : 0);
            case (m_st)
                0: if (sr_enter_req && m_grd == 0 && !acc) m_st <= 1;
                1: if (sr_exit_req) begin m_st <= 2; m_xs <= 0; end
                default: if (m_xs == XRD - 1) m_st <= 0; else m_xs <= m_xs + 1;
            endcase
        end
    end

    task automatic chk(string req, string what, bit got, bit exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "ref_req", ref_req, e_req());
        chk("R4", "ref_urgent", ref_urgent, e_urg());
        chk("R10", "act_block", act_block, e_busy() || e_urg());
        chk("R6", "busy", busy, e_busy());
        chk("R7", "cke", cke, e_cke());
        chk("R8", "nonread_ok", nonread_ok, e_nrd());
        chk("R9", "read_ok", read_ok, e_rd());
        if (ref_urgent) urgent_seen++;
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(bit idle, int grant_pct, bit en, bit ex);
        @(negedge clk);
        compare_all();
        arb_idle = idle; sr_enter_req = en; sr_exit_req = ex;
        #1;
        ref_grant = ref_req && ($urandom_range(99) < grant_pct);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk("R1", "ref_req", ref_req, 1'b0);
        chk("R1", "ref_urgent", ref_urgent, 1'b0);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "act_block", act_block, 1'b0);
        chk("R1", "cke", cke, 1'b1);
        chk("R1", "read_ok", read_ok, 1'b1);
        chk("R1", "nonread_ok", nonread_ok, 1'b1);
        // R2 R4: busy arbiter, no grants, credits pile up to saturation
        repeat (11 * IV) step(1'b0, 0, 1'b0, 1'b0);
        chk("R4", "urgent after saturation", ref_urgent, 1'b1);
        // R5 R6: idle arbiter drains credits as fast as the guard allows
        repeat (6 * IV) step(1'b1, 100, 1'b0, 1'b0);
        // R5: grants offered without a request are ignored
        repeat (40) begin
            @(negedge clk); compare_all();
            arb_idle = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0;
            #1; ref_grant = !ref_req;
        end
        // R7 R8 R9: directed self-refresh with a long stay
        step(1'b0, 0, 1'b1, 1'b0);
        repeat (30) step(1'b0, 0, 1'b0, 1'b0);
        chk("R7", "cke held low", cke, 1'b0);
        step(1'b0, 0, 1'b0, 1'b1);
        repeat (XRD + 30) step(1'b1, 60, 1'b0, 1'b0);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            automatic bit idle = $urandom_range(2) != 0;
            automatic bit en   = $urandom_range(59) == 0;
            automatic bit ex   = $urandom_range(9) == 0;
            step(idle, 40, en, ex);
        end
        chk("R4", "urgency observed", urgent_seen > 0, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule